// File: doc/BRIEF.md
# Shadowed Nonvolatile SRAM Controller

This block models a byte-wide static RAM in which every word has a nonvolatile shadow copy. Both arrays are held as registers. Accesses use active-low chip-select, write-strobe and output-gate inputs, and each is sampled on the rising clock edge: one clock cycle makes one bus cycle. Read data comes out of a register. It is qualified by a drive-enable output, which stands in for a tri-state bus.

No pin starts a transfer. A detector watches the normal bus for six read accesses in a row at fixed addresses. The sixth address chooses the transfer. One value copies the whole SRAM into the shadow (save). The other clears the SRAM and then loads it from the shadow (restore). A write or any other read arriving between two steps of the chain cancels it. Idle cycles with chip-select high do not cancel it.

While a transfer runs, `busy` is high and the block ignores every access. The transfer finishes even if chip-select goes high. Reset behaves like power-up: a restore starts at once, so the SRAM comes back holding the saved contents.

Top module: `shadow_sram`

## Requirements
- R1: The memory holds 2^ADDR_W words of DATA_W bits. A word written at an address is returned by a later read of that address.
- R2: With `ce_n` high nothing is written, and `dout_oe` is low in the following cycle.
- R3: An access with `ce_n` low and `we_n` low writes `din` at `addr`. `dout_oe` is low in the following cycle, whatever `oe_n` is.
- R4: A read (`ce_n` low, `we_n` high, `oe_n` low) on an idle block raises `dout_oe` in the next cycle, with `dout` holding the addressed word.
- R5: A read with `oe_n` high still counts as a read access, but `dout_oe` stays low.
- R6: Six consecutive read accesses start a transfer. The first five must be at SEQ_A0..SEQ_A4, in that order. The sixth is at SAVE_ADDR for a save or at RESTORE_ADDR for a restore. Cycles with `ce_n` high may sit between steps.
- R7: A write, or a read at an address other than the expected one, between steps cancels the chain and no transfer starts. If that read is at SEQ_A0, it counts as the first step of a new chain.
- R8: `busy` rises in the cycle after the final read of the chain. It stays high for exactly max(SAVE_CYCLES, 2^ADDR_W) cycles for a save and max(RESTORE_CYCLES, 2^(ADDR_W+1)) cycles for a restore, whatever `ce_n` does meanwhile.
- R9: While `busy` is high, writes change nothing and reads leave `dout_oe` low.
- R10: A save copies every SRAM word into the shadow and leaves the SRAM contents unchanged.
- R11: A restore first clears every SRAM word and then copies the shadow into it. Words written after the last save return to their saved values.
- R12: A restore never changes the shadow. Repeating it gives the same SRAM contents again.
- R13: After reset is released, a restore runs by itself: `busy` stays high for the restore length, and the data saved before the reset is then readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; accesses are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; release starts a restore |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W | Word address |
| din | input | DATA_W | Write data |
| dout | output | DATA_W | Registered read data |
| dout_oe | output | 1 | High when `dout` would drive the bus |
| busy | output | 1 | High while a save or restore runs |

## Verification
The bench builds the block with ADDR_W = 5, SAVE_CYCLES = 100 and RESTORE_CYCLES = 90. These values make 32-word arrays, a padded 100-cycle save and a 90-cycle restore that is longer than its 64-cycle clear-and-copy floor. Every word can therefore be written and compared after each transfer, and the busy windows can be counted cycle by cycle. Chains are sent with idle gaps, with a write inserted, with a stray read inserted and with a restart at the first address. The bench also drives traffic while `busy` is high and resets with known data already saved.

// File: rtl/nvs_pkg.sv
`timescale 1ns/1ps
package nvs_pkg;

    // Transfer sequencer phases
    typedef enum logic [1:0] {
        XF_IDLE  = 2'd0,
        XF_SAVE  = 2'd1,
        XF_CLEAR = 2'd2,
        XF_LOAD  = 2'd3
    } xfer_e;

    // Number of read steps in the trigger chain, final selector included
    localparam int CHAIN_LEN = 6;

endpackage

// File: rtl/nvs_bank.sv
`timescale 1ns/1ps
module nvs_bank #(
    parameter int ADDR_W = 11,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/nvs_seq_det.sv
`timescale 1ns/1ps
module nvs_seq_det #(
    parameter int ADDR_W       = 11,
    parameter int SEQ_A0       = 'h0E,
    parameter int SEQ_A1       = 'h13,
    parameter int SEQ_A2       = 'h0A,
    parameter int SEQ_A3       = 'h1C,
    parameter int SEQ_A4       = 'h03,
    parameter int SAVE_ADDR    = 'h1F,
    parameter int RESTORE_ADDR = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_read,
    input  logic [ADDR_W-1:0] addr,
    output logic              go_save,
    output logic              go_restore
);
    localparam int STEP_W = $clog2(nvs_pkg::CHAIN_LEN);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(nvs_pkg::CHAIN_LEN - 1);
    localparam logic [ADDR_W-1:0] A0 = ADDR_W'(SEQ_A0);
    localparam logic [ADDR_W-1:0] A1 = ADDR_W'(SEQ_A1);
    localparam logic [ADDR_W-1:0] A2 = ADDR_W'(SEQ_A2);
    localparam logic [ADDR_W-1:0] A3 = ADDR_W'(SEQ_A3);
    localparam logic [ADDR_W-1:0] A4 = ADDR_W'(SEQ_A4);
    localparam logic [ADDR_W-1:0] SV = ADDR_W'(SAVE_ADDR);
    localparam logic [ADDR_W-1:0] RS = ADDR_W'(RESTORE_ADDR);

    typedef struct packed {
        logic [STEP_W-1:0] step;
    } det_t;

    det_t q, d;
    logic [ADDR_W-1:0] want_addr;
    logic              mid_hit;
    logic              at_last;

    always_comb begin
        case (q.step)
            STEP_W'(0): want_addr = A0;
            STEP_W'(1): want_addr = A1;
            STEP_W'(2): want_addr = A2;
            STEP_W'(3): want_addr = A3;
            STEP_W'(4): want_addr = A4;
            default:    want_addr = '0;
        endcase
    end

    always_comb begin
        at_last    = acc_valid && acc_read && (q.step == LAST_STEP);
        mid_hit    = acc_valid && acc_read && (q.step != LAST_STEP) && (addr == want_addr);
        go_save    = at_last && (addr == SV);
        go_restore = at_last && (addr == RS) && (addr != SV);

        d = q;
        if (acc_valid) begin
            if (mid_hit) begin
                d.step = q.step + STEP_W'(1);
            end else if (acc_read && (addr == A0) && !(go_save || go_restore)) begin
                d.step = STEP_W'(1);
            end else begin
                d.step = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/nvs_xfer.sv
`timescale 1ns/1ps
module nvs_xfer #(
    parameter int ADDR_W = 11,
    parameter int ST_LEN = 2048,
    parameter int RC_LEN = 4096
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_save,
    input  logic              go_restore,
    output logic              busy,
    output logic [ADDR_W-1:0] idx,
    output logic              sram_we,
    output logic              sram_zero,
    output logic              shadow_we
);
    import nvs_pkg::*;

    localparam int DEPTH = 1 << ADDR_W;
    localparam int MAXLEN = (ST_LEN > RC_LEN) ? ST_LEN : RC_LEN;
    localparam int CNT_W = $clog2(MAXLEN + 1);
    localparam logic [CNT_W-1:0] C_DEPTH   = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] C_DEPTH2  = CNT_W'(2 * DEPTH);
    localparam logic [CNT_W-1:0] C_CLR_END = CNT_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] C_ST_END  = CNT_W'(ST_LEN - 1);
    localparam logic [CNT_W-1:0] C_RC_END  = CNT_W'(RC_LEN - 1);

    typedef struct packed {
        xfer_e            st;
        logic [CNT_W-1:0] cnt;
    } xf_t;

    xf_t q, d;

    always_comb begin
        d = q;
        case (q.st)
            XF_IDLE: begin
                d.cnt = '0;
                if (go_save) begin
                    d.st = XF_SAVE;
                end else if (go_restore) begin
                    d.st = XF_CLEAR;
                end
            end
            XF_SAVE: begin
                if (q.cnt == C_ST_END) begin
                    d.st  = XF_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
            XF_CLEAR: begin
                d.cnt = q.cnt + CNT_W'(1);
                if (q.cnt == C_CLR_END) begin
                    d.st = XF_LOAD;
                end
            end
            default: begin
                if (q.cnt == C_RC_END) begin
                    d.st  = XF_IDLE;
                    d.cnt = '0;
                end else begin
                    d.cnt = q.cnt + CNT_W'(1);
                end
            end
        endcase
    end

    // Word index is the low part of the phase counter; the array depth is a power of two
    always_comb begin
        busy      = (q.st != XF_IDLE);
        idx       = q.cnt[ADDR_W-1:0];
        shadow_we = (q.st == XF_SAVE) && (q.cnt < C_DEPTH);
        sram_zero = (q.st == XF_CLEAR);
        sram_we   = (q.st == XF_CLEAR) || ((q.st == XF_LOAD) && (q.cnt < C_DEPTH2));
    end

    // Reset lands in the clear phase: a restore follows every reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.st  <= XF_CLEAR;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/shadow_sram.sv
`timescale 1ns/1ps
module shadow_sram #(
    parameter int ADDR_W         = 11,
    parameter int DATA_W         = 8,
    parameter int SAVE_CYCLES    = 16384,
    parameter int RESTORE_CYCLES = 4608,
    parameter int SEQ_A0         = 'h0E,
    parameter int SEQ_A1         = 'h13,
    parameter int SEQ_A2         = 'h0A,
    parameter int SEQ_A3         = 'h1C,
    parameter int SEQ_A4         = 'h03,
    parameter int SAVE_ADDR      = 'h1F,
    parameter int RESTORE_ADDR   = 'h0C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe,
    output logic              busy
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int ST_LEN = (SAVE_CYCLES > DEPTH) ? SAVE_CYCLES : DEPTH;
    localparam int RC_LEN = (RESTORE_CYCLES > 2 * DEPTH) ? RESTORE_CYCLES : 2 * DEPTH;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              drive;
    } out_t;

    out_t q, d;

    logic              acc_ok, acc_rd, acc_wr;
    logic              go_save, go_restore;
    logic              xf_busy, xf_sram_we, xf_zero, xf_shadow_we;
    logic [ADDR_W-1:0] xf_idx;
    logic              sram_we;
    logic [ADDR_W-1:0] sram_waddr, sram_raddr;
    logic [DATA_W-1:0] sram_wdata, sram_rdata, shadow_rdata;

    // Bus decode: the sequencer owns both arrays while it runs
    always_comb begin
        acc_ok = !ce_n && !xf_busy;
        acc_rd = acc_ok && we_n;
        acc_wr = acc_ok && !we_n;
    end

    nvs_seq_det #(
        .ADDR_W      (ADDR_W),
        .SEQ_A0      (SEQ_A0),
        .SEQ_A1      (SEQ_A1),
        .SEQ_A2      (SEQ_A2),
        .SEQ_A3      (SEQ_A3),
        .SEQ_A4      (SEQ_A4),
        .SAVE_ADDR   (SAVE_ADDR),
        .RESTORE_ADDR(RESTORE_ADDR)
    ) i_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .acc_valid (acc_ok),
        .acc_read  (we_n),
        .addr      (addr),
        .go_save   (go_save),
        .go_restore(go_restore)
    );

    nvs_xfer #(
        .ADDR_W(ADDR_W),
        .ST_LEN(ST_LEN),
        .RC_LEN(RC_LEN)
    ) i_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .go_save   (go_save),
        .go_restore(go_restore),
        .busy      (xf_busy),
        .idx       (xf_idx),
        .sram_we   (xf_sram_we),
        .sram_zero (xf_zero),
        .shadow_we (xf_shadow_we)
    );

    always_comb begin
        if (xf_busy) begin
            sram_we    = xf_sram_we;
            sram_waddr = xf_idx;
            sram_wdata = xf_zero ? '0 : shadow_rdata;
            sram_raddr = xf_idx;
        end else begin
            sram_we    = acc_wr;
            sram_waddr = addr;
            sram_wdata = din;
            sram_raddr = addr;
        end
    end

    nvs_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_sram (
        .clk  (clk),
        .we   (sram_we),
        .waddr(sram_waddr),
        .wdata(sram_wdata),
        .raddr(sram_raddr),
        .rdata(sram_rdata)
    );

    nvs_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_shadow (
        .clk  (clk),
        .we   (xf_shadow_we),
        .waddr(xf_idx),
        .wdata(sram_rdata),
        .raddr(xf_idx),
        .rdata(shadow_rdata)
    );

    always_comb begin
        d       = q;
        d.drive = acc_rd && !oe_n;
        if (acc_rd) begin
            d.data = sram_rdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign dout    = q.data;
    assign dout_oe = q.drive;
    assign busy    = xf_busy;

endmodule

// File: rtl/nvs_checker.sv
`timescale 1ns/1ps
module nvs_checker #(
    parameter int ADDR_W       = 11,
    parameter int ST_LEN       = 2048,
    parameter int RC_LEN       = 4096,
    parameter int SAVE_ADDR    = 'h1F,
    parameter int RESTORE_ADDR = 'h0C
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              we_n,
    input logic              oe_n,
    input logic [ADDR_W-1:0] addr,
    input logic              dout_oe,
    input logic              busy
);
    int run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q <= 0;
        end else if (busy) begin
            run_q <= run_q + 1;
        end else begin
            run_q <= 0;
        end
    end

    p_standby_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> !dout_oe);

    p_write_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !we_n) |=> !dout_oe);

    p_read_drives_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !ce_n && we_n && !oe_n) |=> dout_oe);

    p_internal_read_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && we_n && oe_n) |=> !dout_oe);

    p_trigger_by_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(!ce_n && we_n &&
            (addr == ADDR_W'(SAVE_ADDR) || addr == ADDR_W'(RESTORE_ADDR))));

    p_busy_len_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (run_q == ST_LEN || run_q == RC_LEN));

    p_busy_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !dout_oe);

endmodule

bind shadow_sram nvs_checker #(
    .ADDR_W      (ADDR_W),
    .ST_LEN      (ST_LEN),
    .RC_LEN      (RC_LEN),
    .SAVE_ADDR   (SAVE_ADDR),
    .RESTORE_ADDR(RESTORE_ADDR)
) i_nvs_checker (
    .clk    (clk),
    .rst_n  (rst_n),
    .ce_n   (ce_n),
    .we_n   (we_n),
    .oe_n   (oe_n),
    .addr   (addr),
    .dout_oe(dout_oe),
    .busy   (busy)
);

// File: tb/test_shadow_sram.sv
`timescale 1ns/1ps
module test_shadow_sram;
    localparam int AW = 5;
    localparam int DW = 8;
    localparam int WORDS = 1 << AW;
    localparam int SAVE_LEN = 100;
    localparam int REST_LEN = 90;
    localparam logic [AW-1:0] S0 = 5'h0E, S1 = 5'h13, S2 = 5'h0A, S3 = 5'h1C, S4 = 5'h03;
    localparam logic [AW-1:0] SV = 5'h1F, RS = 5'h0C;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe, busy;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shadow_sram #(
        .ADDR_W(AW), .DATA_W(DW),
        .SAVE_CYCLES(SAVE_LEN), .RESTORE_CYCLES(REST_LEN)
    ) i_shadow_sram (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .dout(dout), .dout_oe(dout_oe), .busy(busy)
    );

    function automatic logic [DW-1:0] pat(int i);
        return DW'(i * 37 + 11);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // One bus cycle: drive at a falling edge, return at the next falling edge
    task automatic cyc(logic c, logic w, logic o, logic [AW-1:0] a, logic [DW-1:0] dv);
        ce_n = c; we_n = w; oe_n = o; addr = a; din = dv;
        @(negedge clk);
    endtask

    task automatic idle();
        cyc(1'b1, 1'b1, 1'b1, '0, '0);
    endtask

    task automatic wr(logic [AW-1:0] a, logic [DW-1:0] dv);
        cyc(1'b0, 1'b0, 1'b0, a, dv);
        check("R3 write keeps bus off", int'(dout_oe), 0);
    endtask

    task automatic rd_chk(string req, logic [AW-1:0] a, logic [DW-1:0] exp);
        cyc(1'b0, 1'b1, 1'b0, a, '0);
        check("R4 read drives bus", int'(dout_oe), 1);
        check(req, int'(dout), int'(exp));
    endtask

    task automatic rd_plain(logic [AW-1:0] a);
        cyc(1'b0, 1'b1, 1'b0, a, '0);
    endtask

    task automatic read_all(string req, bit inverted);
        for (int i = 0; i < WORDS; i++) begin
            rd_chk(req, AW'(i), inverted ? ~pat(i) : pat(i));
        end
    endtask

    task automatic write_all(bit inverted);
        for (int i = 0; i < WORDS; i++) begin
            wr(AW'(i), inverted ? ~pat(i) : pat(i));
        end
    endtask

    // Count falling edges with busy high; optional traffic during the window
    task automatic measure_busy(string req, int exp, bit hostile);
        int n = 0;
        while (busy && n < 1000) begin
            n++;
            if (!hostile) begin
                idle();
            end else if (n % 2 == 1) begin
                wr(5'h02, 8'hA5);
            end else begin
                cyc(1'b0, 1'b1, 1'b0, S0, '0);
                check("R9 read blocked while busy", int'(dout_oe), 0);
            end
        end
        check(req, n, exp);
    endtask

    task automatic send_chain(logic [AW-1:0] last, bit gaps);
        rd_plain(S0);
        if (gaps) idle();
        rd_plain(S1);
        rd_plain(S2);
        if (gaps) begin idle(); idle(); end
        rd_plain(S3);
        rd_plain(S4);
        if (gaps) idle();
        rd_plain(last);
    endtask

    task automatic do_reset(string req);
        rst_n = 1'b0;
        idle(); idle(); idle();
        rst_n = 1'b1;
        check("R13 busy at reset release", int'(busy), 1);
        check("R2 bus off after reset", int'(dout_oe), 0);
        measure_busy(req, REST_LEN, 1'b0);
    endtask

    task automatic t_power_up();
        do_reset("R13 automatic restore length");
    endtask

    task automatic t_basic_rw();
        write_all(1'b0);
        read_all("R1 write then read", 1'b0);
        cyc(1'b0, 1'b1, 1'b1, 5'h03, '0);
        check("R5 internal read keeps bus off", int'(dout_oe), 0);
        cyc(1'b1, 1'b0, 1'b0, 5'h07, 8'hEE);
        check("R2 standby keeps bus off", int'(dout_oe), 0);
        rd_chk("R2 standby did not write", 5'h07, pat(7));
    endtask

    task automatic t_save();
        send_chain(SV, 1'b1);
        check("R6 save chain with gaps starts busy", int'(busy), 1);
        measure_busy("R8 save length", SAVE_LEN, 1'b1);
        rd_chk("R9 write during busy ignored", 5'h02, pat(2));
        read_all("R10 save leaves SRAM intact", 1'b0);
    endtask

    task automatic t_restore();
        write_all(1'b1);
        read_all("R1 overwrite before restore", 1'b1);
        send_chain(RS, 1'b0);
        check("R6 restore chain starts busy", int'(busy), 1);
        measure_busy("R8 restore length", REST_LEN, 1'b0);
        read_all("R11 restore brings saved data", 1'b0);
    endtask

    task automatic t_restore_again();
        for (int i = 0; i < WORDS; i += 3) begin
            wr(AW'(i), 8'h00);
        end
        send_chain(RS, 1'b1);
        measure_busy("R8 second restore length", REST_LEN, 1'b0);
        read_all("R12 repeated restore same data", 1'b0);
    endtask

    task automatic t_abort();
        wr(5'h09, 8'h3C);
        rd_plain(S0); rd_plain(S1); rd_plain(S2); rd_plain(S3);
        wr(5'h09, 8'h3C);
        rd_plain(S4); rd_plain(RS);
        check("R7 write aborts chain", int'(busy), 0);
        rd_chk("R7 no restore after write abort", 5'h09, 8'h3C);
        rd_plain(S0); rd_plain(S1); rd_plain(5'h05);
        rd_plain(S2); rd_plain(S3); rd_plain(S4); rd_plain(RS);
        check("R7 stray read aborts chain", int'(busy), 0);
        rd_chk("R7 no restore after stray read", 5'h09, 8'h3C);
        rd_plain(S0); rd_plain(S1); rd_plain(S0);
        rd_plain(S1); rd_plain(S2); rd_plain(S3); rd_plain(S4); rd_plain(RS);
        check("R7 restart at first address fires", int'(busy), 1);
        measure_busy("R8 restore after restart", REST_LEN, 1'b0);
        rd_chk("R7 restore after restart", 5'h09, pat(9));
    endtask

    task automatic t_reset_keeps_data();
        write_all(1'b1);
        do_reset("R13 restore length after reset");
        read_all("R13 saved data back after reset", 1'b0);
    endtask

    initial begin
        @(negedge clk);
        t_power_up();
        t_basic_rw();
        t_save();
        t_restore();
        t_restore_again();
        t_abort();
        t_reset_keeps_data();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule